// File: doc/BRIEF.md
# Saturating Packed SIMD Arithmetic Unit

This unit performs signed saturating addition and subtraction on two 32-bit operands. A 4-bit operation code picks the lane layout. The operands can be handled as a single 32-bit word, as two 16-bit halves or as four bytes. In every lane, both fields are sign-extended and combined at full precision. The lane result is then clamped to the signed range of that lane's width. Two cross-halfword forms pair each low half of the first operand with the high half of the second operand, and the reverse. Two doubling forms first double the second operand with saturation and then add it to, or subtract it from, the first operand with saturation.

The caller supplies the current sticky saturation flag with every operation. Only the 32-bit forms can raise this flag. Every other code passes the flag through unchanged. The arithmetic is combinational. Result and flag are captured in one output register stage, so each operation's answer appears on the outputs one clock edge after it is presented. The stage has a synchronous active-low reset.

Top module: `sat_simd_alu`

## Requirements
- R1: Op code 0 (word add) and op code 1 (word subtract) return `a+b` and `a-b` on the full 32-bit signed operands. A result above 0x7FFFFFFF clamps to 0x7FFFFFFF, and a result below 0x80000000 (as a signed value) clamps to 0x80000000.
- R2: Op code 2 (doubling add) returns `a + sat(2*b)`, and op code 3 (doubling subtract) returns `a - sat(2*b)`. Both the doubling step and the add or subtract step are clamped to the signed 32-bit range.
- R3: The flag output is 1 when a 32-bit form (codes 0 to 3) clamps in any of its steps. For the doubling forms, a clamp in either step counts.
- R4: The flag is sticky. If the incoming flag is 1, the flag output is 1 for every op code.
- R5: Op code 4 (halfword add) and op code 5 (halfword subtract) work on two independent lanes, bits 15..0 and bits 31..16. Each lane clamps to 0x7FFF or 0x8000.
- R6: Op code 6 (byte add) and op code 7 (byte subtract) work on four independent lanes at bits 8i+7..8i. Each lane clamps to 0x7F or 0x80.
- R7: Op code 8 (exchange add/subtract) puts `a.lo - b.hi` in bits 15..0 and `a.hi + b.lo` in bits 31..16. Each half is clamped to 16 bits.
- R8: Op code 9 (exchange subtract/add) puts `a.lo + b.hi` in bits 15..0 and `a.hi - b.lo` in bits 31..16. Each half is clamped to 16 bits.
- R9: For codes 4 to 9, the flag output equals the incoming flag, even when a lane clamps.
- R10: Codes 10 to 15 return a result of zero, and the flag output equals the incoming flag.
- R11: Result and flag appear one clock edge after the inputs are presented. While reset is low at a clock edge, both outputs become zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code (0 to 9 valid) |
| src_a_i | input | 32 | First operand |
| src_b_i | input | 32 | Second operand |
| q_i | input | 1 | Current sticky saturation flag |
| result_o | output | 32 | Registered result |
| q_o | output | 1 | Registered updated saturation flag |

## Verification
Every result and flag is due exactly one rising edge after its inputs are applied. The bench therefore drives each operation on a falling edge and compares both outputs on the next falling edge. At that point the register stage has captured exactly that operation and nothing later. The expected values come from a wide signed integer model that clamps each lane separately. Directed cases sit at every lane's maximum and minimum, including doubling values that saturate only in the first step. These are mixed with random and corner-biased operands under every op code.

// File: rtl/sat_simd_pkg.sv
// Package: operation codes and width constants shared by the saturating unit.
package sat_simd_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [3:0] {
        OP_ADD32  = 4'd0,
        OP_SUB32  = 4'd1,
        OP_DADD32 = 4'd2,
        OP_DSUB32 = 4'd3,
        OP_ADD16  = 4'd4,
        OP_SUB16  = 4'd5,
        OP_ADD8   = 4'd6,
        OP_SUB8   = 4'd7,
        OP_XAS16  = 4'd8,
        OP_XSA16  = 4'd9
    } sat_op_e;

    localparam logic [3:0] OP_LAST = 4'd9;
endpackage

// File: rtl/sat_lane.sv
// Module: sat_lane
// One signed lane of width W. Both fields are sign-extended by one bit and
// added or subtracted. The lane reports whether the exact result fell outside
// the W-bit signed range, and if so returns the nearest representable limit.
// Assumes two's complement operands. Purely combinational.
module sat_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         sat_o
);
    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    logic [W:0] ax, bx, full;

    // Purpose: widen, combine at W+1 bits, detect overflow, clamp.
    always_comb begin
        ax    = {a_i[W-1], a_i};
        bx    = {b_i[W-1], b_i};
        full  = sub_i ? (ax - bx) : (ax + bx);
        sat_o = full[W] ^ full[W-1];
        if (!sat_o)
            res_o = full[W-1:0];
        else if (full[W])
            res_o = NEG_LIM;
        else
            res_o = POS_LIM;
    end
endmodule

// File: rtl/sat_packed.sv
// Module: sat_packed
// N independent saturating lanes tiled across a DW-bit word. Lane i occupies
// bits i*LW+LW-1 .. i*LW. Each lane has its own add/subtract select.
// Any exchange of halves is done by the caller before the operands arrive.
module sat_packed #(
    parameter int DW = 32,
    parameter int N  = 4
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic [N-1:0]  sub_i,
    output logic [DW-1:0] res_o,
    output logic [N-1:0]  sat_o
);
    localparam int LW = DW / N;

    // Purpose: instantiate one clamping lane per field.
    for (genvar i = 0; i < N; i++) begin : g_lane
        sat_lane #(.W(LW)) u_lane (
            .a_i  (a_i[i*LW +: LW]),
            .b_i  (b_i[i*LW +: LW]),
            .sub_i(sub_i[i]),
            .res_o(res_o[i*LW +: LW]),
            .sat_o(sat_o[i])
        );
    end
endmodule

// File: rtl/sat_word_path.sv
// Module: sat_word_path
// Full-width saturating path. Optionally doubles b with saturation first, then
// adds the (possibly doubled) value to a or subtracts it from a, with
// saturation. sat_o is the OR of both steps' overflow. When doubling is off,
// the first step's overflow is ignored.
module sat_word_path #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          dbl_i,
    input  logic          sub_i,
    output logic [DW-1:0] res_o,
    output logic          sat_o
);
    logic [DW-1:0] dbl_res, second;
    logic          dbl_sat, main_sat;

    sat_lane #(.W(DW)) u_double (
        .a_i(b_i), .b_i(b_i), .sub_i(1'b0),
        .res_o(dbl_res), .sat_o(dbl_sat)
    );

    // Purpose: select the raw or doubled second operand.
    always_comb second = dbl_i ? dbl_res : b_i;

    sat_lane #(.W(DW)) u_main (
        .a_i(a_i), .b_i(second), .sub_i(sub_i),
        .res_o(res_o), .sat_o(main_sat)
    );

    // Purpose: merge overflow of the steps that were actually used.
    always_comb sat_o = main_sat | (dbl_i & dbl_sat);
endmodule

// File: rtl/sat_simd_alu.sv
// Module: sat_simd_alu (top)
// Decodes the operation code, steers the operands into the word path, the
// halfword lanes (exchanging b's halves for the cross forms) and the byte
// lanes, and selects the result. Only the word forms may raise the sticky
// flag. Result and flag are registered once, with a synchronous active-low
// reset. Assumes op_i is stable around the rising edge.
module sat_simd_alu
    import sat_simd_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_i,
    input  logic [DW-1:0] src_a_i,
    input  logic [DW-1:0] src_b_i,
    input  logic          q_i,
    output logic [DW-1:0] result_o,
    output logic          q_o
);
    localparam int HW = DW / 2;

    logic          is_word, is_half, is_byte, is_xchg, op_valid;
    logic          w_dbl, w_sub;
    logic [1:0]    h_sub;
    logic [3:0]    b_sub;
    logic [DW-1:0] h_b;
    logic [DW-1:0] w_res, h_res, b_res, res_nxt;
    logic          w_sat;
    logic [1:0]    h_sat;
    logic [3:0]    b_sat;
    logic          q_nxt;

    // Purpose: classify the op code and derive per-path controls.
    always_comb begin
        op_valid = (op_i <= OP_LAST);
        is_word  = (op_i == OP_ADD32) || (op_i == OP_SUB32) ||
                   (op_i == OP_DADD32) || (op_i == OP_DSUB32);
        is_xchg  = (op_i == OP_XAS16) || (op_i == OP_XSA16);
        is_half  = (op_i == OP_ADD16) || (op_i == OP_SUB16) || is_xchg;
        is_byte  = (op_i == OP_ADD8) || (op_i == OP_SUB8);
        w_dbl    = (op_i == OP_DADD32) || (op_i == OP_DSUB32);
        w_sub    = (op_i == OP_SUB32) || (op_i == OP_DSUB32);
        case (op_i)
            OP_SUB16: h_sub = 2'b11;
            OP_XAS16: h_sub = 2'b01;
            OP_XSA16: h_sub = 2'b10;
            default:  h_sub = 2'b00;
        endcase
        b_sub = {4{op_i == OP_SUB8}};
    end

    // Purpose: swap b's halves for the cross-halfword forms.
    always_comb h_b = is_xchg ? {src_b_i[HW-1:0], src_b_i[DW-1:HW]} : src_b_i;

    sat_word_path #(.DW(DW)) u_word (
        .a_i(src_a_i), .b_i(src_b_i), .dbl_i(w_dbl), .sub_i(w_sub),
        .res_o(w_res), .sat_o(w_sat)
    );

    sat_packed #(.DW(DW), .N(2)) u_half (
        .a_i(src_a_i), .b_i(h_b), .sub_i(h_sub),
        .res_o(h_res), .sat_o(h_sat)
    );

    sat_packed #(.DW(DW), .N(4)) u_byte (
        .a_i(src_a_i), .b_i(src_b_i), .sub_i(b_sub),
        .res_o(b_res), .sat_o(b_sat)
    );

    // Purpose: pick the path result and form the next sticky flag.
    always_comb begin
        if (is_word)      res_nxt = w_res;
        else if (is_half) res_nxt = h_res;
        else if (is_byte) res_nxt = b_res;
        else              res_nxt = '0;
        q_nxt = q_i | (is_word & w_sat);
    end

    // Purpose: output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            q_o      <= 1'b0;
        end else begin
            result_o <= res_nxt;
            q_o      <= q_nxt;
        end
    end

    // ---------------- assertions ----------------
    p_q_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q_i |=> q_o);

    p_word_sat_sets_q_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_word && w_sat) |=> q_o);

    p_packed_q_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_half || is_byte) |=> (q_o == $past(q_i)));

    p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid) |=> (result_o == '0 && q_o == $past(q_i)));

    p_add_zero_ident_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ADD32 && src_a_i == '0) |=> (result_o == $past(src_b_i)));

    p_byte_lanes_indep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ADD8 && src_b_i == '0) |=> (result_o == $past(src_a_i)));
endmodule

// File: tb/tb_sat_simd_alu.sv
module tb_sat_simd_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] src_a_i = '0, src_b_i = '0;
    logic        q_i = 1'b0;
    logic [31:0] result_o;
    logic        q_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    sat_simd_alu dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .src_a_i(src_a_i),
        .src_b_i(src_b_i), .q_i(q_i), .result_o(result_o), .q_o(q_o)
    );

    function automatic longint sx(logic [31:0] v, int lo, int w);
        longint r = longint'((v >> lo) & ((64'd1 << w) - 1));
        if (r[w-1]) r = r - (64'sd1 <<< w);
        return r;
    endfunction

    function automatic longint clampv(longint v, int w, ref bit s);
        longint mx = (64'sd1 <<< (w - 1)) - 1;
        longint mn = -mx - 1;
        if (v > mx) begin s = 1; return mx; end
        if (v < mn) begin s = 1; return mn; end
        return v;
    endfunction

    function automatic string rtag(logic [3:0] op);
        case (op)
            0, 1:    return "R1";
            2, 3:    return "R2";
            4, 5:    return "R5";
            6, 7:    return "R6";
            8:       return "R7";
            9:       return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic model(input logic [3:0] op, input logic [31:0] a, b,
                         input logic qin, output logic [31:0] r, output logic q);
        bit s = 0;
        longint v, d;
        logic [63:0] t;
        r = '0;
        case (op)
            0, 1: begin
                v = (op == 0) ? sx(a,0,32) + sx(b,0,32) : sx(a,0,32) - sx(b,0,32);
                t = clampv(v, 32, s); r = t[31:0];
            end
            2, 3: begin
                d = clampv(2 * sx(b,0,32), 32, s);
                v = (op == 2) ? sx(a,0,32) + d : sx(a,0,32) - d;
                t = clampv(v, 32, s); r = t[31:0];
            end
            4, 5, 8, 9: begin
                bit ds = 0;
                longint lo, hi;
                case (op)
                    4: begin lo = sx(a,0,16)+sx(b,0,16);  hi = sx(a,16,16)+sx(b,16,16); end
                    5: begin lo = sx(a,0,16)-sx(b,0,16);  hi = sx(a,16,16)-sx(b,16,16); end
                    8: begin lo = sx(a,0,16)-sx(b,16,16); hi = sx(a,16,16)+sx(b,0,16); end
                    default: begin lo = sx(a,0,16)+sx(b,16,16); hi = sx(a,16,16)-sx(b,0,16); end
                endcase
                t = clampv(lo, 16, ds); r[15:0] = t[15:0];
                t = clampv(hi, 16, ds); r[31:16] = t[15:0];
            end
            6, 7: begin
                bit ds = 0;
                for (int i = 0; i < 4; i++) begin
                    v = (op == 6) ? sx(a,8*i,8) + sx(b,8*i,8) : sx(a,8*i,8) - sx(b,8*i,8);
                    t = clampv(v, 8, ds);
                    r[8*i +: 8] = t[7:0];
                end
            end
            default: r = '0;
        endcase
        q = qin | s;
    endtask

    task automatic cmp(input string tag, input logic [31:0] er, input logic eq);
        n_cmp++;
        if (result_o !== er || q_o !== eq) begin
            n_bad++;
            $display("FAIL %s: result=%h q=%b expected result=%h q=%b",
                     tag, result_o, q_o, er, eq);
        end
    endtask

    // Drive at falling edge, result due after next rising edge; compare at next falling edge.
    task automatic run(input logic [3:0] op, input logic [31:0] a, b, input logic qin);
        logic [31:0] er;
        logic eq;
        string tag;
        op_i = op; src_a_i = a; src_b_i = b; q_i = qin;
        model(op, a, b, qin, er, eq);
        tag = rtag(op);
        if (qin) tag = {tag, "/R4"};
        else if (op <= 3) tag = {tag, "/R3"};
        else tag = {tag, "/R9/R11"};
        @(posedge clk);
        @(negedge clk);
        cmp(tag, er, eq);
    endtask

    function automatic logic [31:0] pick();
        logic [31:0] c [8] = '{32'h7FFFFFFF, 32'h80000000, 32'h00000001, 32'hFFFFFFFF,
                              32'h7FFF7FFF, 32'h80008000, 32'h7F7F7F7F, 32'h80808080};
        if ($urandom_range(0, 3) == 0) return c[$urandom_range(0, 7)];
        return $urandom();
    endfunction

    initial begin
        #(8 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: expired, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R11 reset: outputs zero while reset is low, inputs busy
        op_i = 4'd0; src_a_i = 32'h7FFFFFFF; src_b_i = 32'h1; q_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp("R11 reset", 32'h0, 1'b0);
        rst_n = 1'b1;

        // R1 word clamps
        run(4'd0, 32'h7FFFFFFF, 32'h00000001, 1'b0);
        run(4'd0, 32'h80000000, 32'hFFFFFFFF, 1'b0);
        run(4'd1, 32'h80000000, 32'h00000001, 1'b0);
        run(4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 1'b0);
        run(4'd0, 32'h00001234, 32'h00000010, 1'b0);
        // R2 doubling: first-step-only saturation and exact negative limit
        run(4'd2, 32'h00000000, 32'h40000000, 1'b0);
        run(4'd2, 32'h00000000, 32'hC0000000, 1'b0);
        run(4'd3, 32'h00000000, 32'hC0000000, 1'b0);
        run(4'd3, 32'hFFFFFFFF, 32'h3FFFFFFF, 1'b0);
        run(4'd2, 32'h7FFFFFF0, 32'h00000010, 1'b0);
        // R5 halfword clamps
        run(4'd4, 32'h7FFF8000, 32'h0001FFFF, 1'b0);
        run(4'd5, 32'h80007FFF, 32'h0001FFFF, 1'b0);
        // R6 byte clamps
        run(4'd6, 32'h7F807F80, 32'h01FF01FF, 1'b0);
        run(4'd7, 32'h807F807F, 32'h01FF01FF, 1'b0);
        // R7 / R8 exchange
        run(4'd8, 32'h7FFF8000, 32'h00010001, 1'b0);
        run(4'd9, 32'h80007FFF, 32'h00010001, 1'b0);
        run(4'd8, 32'h00050003, 32'h00020007, 1'b0);
        run(4'd9, 32'h00050003, 32'h00020007, 1'b0);
        // R10 unused codes with both flag values
        for (int c = 10; c < 16; c++) begin
            run(4'(c), 32'hDEADBEEF, 32'h12345678, 1'b0);
            run(4'(c), 32'hDEADBEEF, 32'h12345678, 1'b1);
        end
        // R4 sticky with non-saturating word op
        run(4'd0, 32'h1, 32'h1, 1'b1);
        // random sweep, every op code
        for (int i = 0; i < 4000; i++)
            run(4'($urandom_range(0, 15)), pick(), pick(), 1'($urandom_range(0, 1)));

        // R11 reset mid-run clears outputs
        op_i = 4'd0; src_a_i = 32'h7FFFFFFF; src_b_i = 32'h7FFFFFFF; q_i = 1'b1;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cmp("R11 reset mid-run", 32'h0, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule